// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit sits beside a UART's serial datapath and turns four interrupt conditions into one interrupt line and one status byte. The four conditions are a receive line error, received data ready, transmit holding register empty and a modem status change. Each one arrives as a single-cycle event pulse. The host sets a per-source enable mask. A source whose enable bit is clear never becomes pending. Enabled events latch into per-source pending flags. A fixed four-level priority resolver then picks the single most urgent pending source. It encodes that source into the status byte, and the host's service routine uses the byte to jump to the right handler.

Pending flags clear through the side effects of normal register traffic. Reading the line status register clears the line error flag. Reading the receive buffer clears the data-ready flag. Reading the modem status register clears the modem flag. The transmit-empty flag clears in either of two ways: a write to the transmit holding register, or a read of the status byte while transmit-empty is the source being reported. The interrupt output is a level. It stays high while any enabled source is pending.

The register bus is a plain strobe interface. Read data is combinational from the current address. Side effects take place at the clock edge that ends a strobed access.

Top module: `uart_irq_ident`

## Requirements
- R1: After synchronous reset, the status byte reads 0x01, the enable register reads 0x00 and `irq` is low.
- R2: The enable register sits at address 1. Writing it stores `bus_wdata[3:0]`, and it reads back as {4'b0000, mask}. The mask bits are: bit 0 data ready, bit 1 transmit empty, bit 2 line error, bit 3 modem.
- R3: An event on a source whose enable bit is 0 does not set its pending flag and does not raise `irq`.
- R4: Status bit 0 is 0 while an enabled source is pending and 1 otherwise. Status bits 7:4 always read 0. The status byte is at address 2.
- R5: Status bits 3:1 hold 011 for line error, 010 for data ready, 001 for transmit empty and 000 for modem. They hold 000 when nothing is pending.
- R6: Priority runs line error > data ready > transmit empty > modem. Only the highest pending source is reported, and a lower source shows once every higher one is cleared.
- R7: A read strobe at address 5 (line status) clears the line error flag.
- R8: A read strobe at address 0 (receive buffer) clears the data-ready flag.
- R9: A read strobe at address 6 (modem status) clears the modem flag.
- R10: A write strobe at address 0 (transmit holding) clears the transmit-empty flag.
- R11: A read strobe at address 2 clears the transmit-empty flag only when transmit-empty is the source being reported in that cycle. Otherwise the read leaves the flag unchanged.
- R12: `irq` is high in every cycle in which at least one enabled source is pending.
- R13: An event that arrives in the same cycle as its clearing access wins: the flag is pending afterwards.
- R14: Writing 0 to a source's enable bit discards that source's pending flag. Setting the enable bit again does not bring the flag back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_line_err | input | 1 | Receive line error event pulse |
| ev_rx_ready | input | 1 | Received data ready event pulse |
| ev_tx_empty | input | 1 | Transmit holding register empty event pulse |
| ev_modem | input | 1 | Modem status change event pulse |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data (enable mask bits) |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the unit with its default parameters. These are a 3-bit address, an 8-bit read path and the addresses 0, 1, 2, 5 and 6. With that map, every clearing access is a reachable address, and so are the unused addresses that must read as zero. The directed sequences cover priority hand-over through every level. They also cover the conditional transmit-empty clear from a status read, set-versus-clear collisions, and masking while a flag is pending. A long random phase then mixes all four events with accesses to every address, checked against the reference model on every cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC   = 4;
    localparam int CODE_W = 3;

    // Priority order: index 0 is the most urgent source.
    typedef enum logic [1:0] {
        SRC_LINE    = 2'd0,
        SRC_RXRDY   = 2'd1,
        SRC_TXEMPTY = 2'd2,
        SRC_MODEM   = 2'd3
    } src_e;

    // Decoded side-effect strobes from the register bus.
    typedef struct packed {
        logic rd_lsr;
        logic rd_rbr;
        logic rd_msr;
        logic wr_thr;
        logic rd_isr;
    } bus_side_t;

    typedef struct packed {
        logic valid;
        src_e src;
    } winner_t;

    function automatic logic [CODE_W-1:0] src_code(src_e s);
        logic [CODE_W-1:0] c;
        case (s)
            SRC_LINE:    c = 3'b011;
            SRC_RXRDY:   c = 3'b010;
            SRC_TXEMPTY: c = 3'b001;
            default:     c = 3'b000;
        endcase
        return c;
    endfunction

    // Host mask layout (bit0 rx, bit1 tx, bit2 line, bit3 modem) to priority order.
    function automatic logic [NSRC-1:0] mask_to_prio(logic [NSRC-1:0] m);
        logic [NSRC-1:0] p;
        p[SRC_LINE]    = m[2];
        p[SRC_RXRDY]   = m[0];
        p[SRC_TXEMPTY] = m[1];
        p[SRC_MODEM]   = m[3];
        return p;
    endfunction

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int A_DATA = 0,
    parameter int A_IEN  = 1,
    parameter int A_ISR  = 2,
    parameter int A_LSR  = 5,
    parameter int A_MSR  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   mask_q,
    output logic [NSRC-1:0]   mask_d,
    output bus_side_t         side
);

    localparam logic [ADDR_W-1:0] AD_DATA = ADDR_W'(A_DATA);
    localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] AD_ISR  = ADDR_W'(A_ISR);
    localparam logic [ADDR_W-1:0] AD_LSR  = ADDR_W'(A_LSR);
    localparam logic [ADDR_W-1:0] AD_MSR  = ADDR_W'(A_MSR);

    always_comb begin
        mask_d = mask_q;
        if (bus_wr && bus_addr == AD_IEN)
            mask_d = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    always_comb begin
        side.rd_lsr = bus_rd && (bus_addr == AD_LSR);
        side.rd_rbr = bus_rd && (bus_addr == AD_DATA);
        side.rd_msr = bus_rd && (bus_addr == AD_MSR);
        side.wr_thr = bus_wr && (bus_addr == AD_DATA);
        side.rd_isr = bus_rd && (bus_addr == AD_ISR);
    end

endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] ev,
    input  logic [NSRC-1:0] en_cur,
    input  logic [NSRC-1:0] en_nxt,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend_q
);

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        logic set_k;
        logic nxt_k;
        always_comb begin
            set_k = ev[k] && en_cur[k];
            // A fresh event beats a clear; dropping the enable discards the flag.
            nxt_k = en_nxt[k] && ((pend_q[k] && !clr[k]) || set_k);
        end
        always_ff @(posedge clk) begin
            if (rst) pend_q[k] <= 1'b0;
            else     pend_q[k] <= nxt_k;
        end
    end

endmodule

// File: rtl/uart_irq_resolve.sv
module uart_irq_resolve
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NSRC-1:0]   vis,
    output winner_t           win,
    output logic [DATA_W-1:0] isr
);

    always_comb begin
        win.valid = 1'b0;
        win.src   = SRC_MODEM;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (vis[k]) begin
                win.valid = 1'b1;
                win.src   = src_e'(k[1:0]);
            end
        end
    end

    always_comb begin
        isr    = '0;
        isr[0] = !win.valid;
        if (win.valid)
            isr[CODE_W:1] = src_code(win.src);
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int A_DATA = 0,
    parameter int A_IEN  = 1,
    parameter int A_ISR  = 2,
    parameter int A_LSR  = 5,
    parameter int A_MSR  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_line_err,
    input  logic              ev_rx_ready,
    input  logic              ev_tx_empty,
    input  logic              ev_modem,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] AD_IEN = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] AD_ISR = ADDR_W'(A_ISR);

    logic [NSRC-1:0]   mask_q, mask_d;
    logic [NSRC-1:0]   en_cur, en_nxt;
    logic [NSRC-1:0]   ev_vec, clr_vec, pend_q, vis;
    bus_side_t         side;
    winner_t           win;
    logic [DATA_W-1:0] isr_vec;

    uart_irq_regs #(
        .ADDR_W(ADDR_W), .A_DATA(A_DATA), .A_IEN(A_IEN),
        .A_ISR(A_ISR), .A_LSR(A_LSR), .A_MSR(A_MSR)
    ) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .mask_q(mask_q), .mask_d(mask_d), .side(side)
    );

    always_comb begin
        en_cur = mask_to_prio(mask_q);
        en_nxt = mask_to_prio(mask_d);
        ev_vec[SRC_LINE]    = ev_line_err;
        ev_vec[SRC_RXRDY]   = ev_rx_ready;
        ev_vec[SRC_TXEMPTY] = ev_tx_empty;
        ev_vec[SRC_MODEM]   = ev_modem;
        clr_vec[SRC_LINE]    = side.rd_lsr;
        clr_vec[SRC_RXRDY]   = side.rd_rbr;
        clr_vec[SRC_MODEM]   = side.rd_msr;
        clr_vec[SRC_TXEMPTY] = side.wr_thr ||
            (side.rd_isr && win.valid && win.src == SRC_TXEMPTY);
    end

    uart_irq_pending u_pend (
        .clk(clk), .rst(rst), .ev(ev_vec), .en_cur(en_cur),
        .en_nxt(en_nxt), .clr(clr_vec), .pend_q(pend_q)
    );

    assign vis = pend_q & en_cur;

    uart_irq_resolve #(.DATA_W(DATA_W)) u_res (
        .vis(vis), .win(win), .isr(isr_vec)
    );

    assign irq = |vis;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AD_ISR)      bus_rdata = isr_vec;
        else if (bus_addr == AD_IEN) bus_rdata[NSRC-1:0] = mask_q;
    end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int A_DATA = 0,
    parameter int A_IEN  = 1,
    parameter int A_LSR  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_line_err,
    input logic              ev_tx_empty,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              irq,
    input logic [NSRC-1:0]   pend_q,
    input logic [NSRC-1:0]   en_cur,
    input logic [DATA_W-1:0] isr_vec
);

    localparam logic [ADDR_W-1:0] AD_DATA = ADDR_W'(A_DATA);
    localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] AD_LSR  = ADDR_W'(A_LSR);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && pend_q == '0 && en_cur == '0));

    // R3
    masked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        !en_cur[SRC_LINE] |=> !pend_q[SRC_LINE]);

    // R4
    status_vs_irq_chk: assert property (@(posedge clk) disable iff (rst)
        isr_vec[0] == !irq);

    // R6
    line_first_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q[SRC_LINE] && en_cur[SRC_LINE]) |-> isr_vec[3:1] == 3'b011);

    // R7
    lsr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == AD_LSR && !ev_line_err) |=> !pend_q[SRC_LINE]);

    // R10
    thr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AD_DATA && !ev_tx_empty) |=> !pend_q[SRC_TXEMPTY]);

    // R13
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_line_err && en_cur[SRC_LINE] && !(bus_wr && bus_addr == AD_IEN))
        |=> pend_q[SRC_LINE]);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_DATA(A_DATA), .A_IEN(A_IEN), .A_LSR(A_LSR)
) u_chk (
    .clk(clk), .rst(rst), .ev_line_err(ev_line_err), .ev_tx_empty(ev_tx_empty),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .irq(irq),
    .pend_q(pend_q), .en_cur(en_cur), .isr_vec(isr_vec)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_line_err = 0, ev_rx_ready = 0, ev_tx_empty = 0, ev_modem = 0;
    logic [2:0] bus_addr = 0;
    logic       bus_rd = 0, bus_wr = 0;
    logic [3:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Model state: pend index 0 line, 1 rx, 2 tx, 3 modem; mask in host layout.
    bit       mp[4];
    bit [3:0] mm;

    always #5 clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst(rst), .ev_line_err(ev_line_err), .ev_rx_ready(ev_rx_ready),
        .ev_tx_empty(ev_tx_empty), .ev_modem(ev_modem), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int mbit(int k);
        case (k)
            0: return 2;
            1: return 0;
            2: return 1;
            default: return 3;
        endcase
    endfunction

    function automatic int top_src();
        for (int k = 0; k < 4; k++)
            if (mp[k] && mm[mbit(k)]) return k;
        return -1;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(bit [3:0] ev, bit [2:0] a, bit rd, bit wr, bit [3:0] wd, string tag);
        int w;
        bit [7:0] exp_rd;
        bit clr[4];
        bit [3:0] nm;
        @(negedge clk);
        ev_line_err = ev[0]; ev_rx_ready = ev[1]; ev_tx_empty = ev[2]; ev_modem = ev[3];
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        #4;
        w = top_src();
        exp_rd = 8'h00;
        if (a == 3'd2) exp_rd = (w < 0) ? 8'h01 : 8'((3 - w) << 1);
        else if (a == 3'd1) exp_rd = {4'b0, mm};
        check(tag, bus_rdata, exp_rd);
        check("R12", {7'b0, irq}, {7'b0, w >= 0});
        @(posedge clk);
        clr[0] = rd && a == 3'd5;
        clr[1] = rd && a == 3'd0;
        clr[3] = rd && a == 3'd6;
        clr[2] = (wr && a == 3'd0) || (rd && a == 3'd2 && w == 2);
        nm = (wr && a == 3'd1) ? wd : mm;
        for (int k = 0; k < 4; k++) begin
            bit n;
            n = (mp[k] && !clr[k]) || (ev[k] && mm[mbit(k)]);
            if (!nm[mbit(k)]) n = 0;
            mp[k] = n;
        end
        mm = nm;
    endtask

    task automatic rd_at(bit [2:0] a, string tag);
        cyc(4'b0, a, 1, 0, 4'b0, tag);
    endtask

    task automatic peek(string tag);
        cyc(4'b0, 3'd3, 0, 0, 4'b0, tag);
        cyc(4'b0, 3'd2, 0, 0, 4'b0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) mp[k] = 0;
        mm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset values
        peek("R1");
        cyc(4'b0, 3'd1, 0, 0, 4'b0, "R1");

        // R2 mask write and readback
        cyc(4'b0, 3'd1, 0, 1, 4'hF, "R2");
        cyc(4'b0, 3'd1, 0, 0, 4'b0, "R2");
        cyc(4'b0, 3'd1, 0, 1, 4'h5, "R2");
        cyc(4'b0, 3'd1, 0, 0, 4'b0, "R2");

        // R3 all masked, all events
        cyc(4'b0, 3'd1, 0, 1, 4'h0, "R3");
        cyc(4'b1111, 3'd2, 0, 0, 4'b0, "R3");
        peek("R3");

        // R5 / R11 tx only, status read clears it
        cyc(4'b0, 3'd1, 0, 1, 4'h2, "R5");
        cyc(4'b0100, 3'd2, 0, 0, 4'b0, "R5");
        rd_at(3'd2, "R11");
        peek("R11");

        // R6 priority chain with each clear (R7 R8 R9 R11)
        cyc(4'b0, 3'd1, 0, 1, 4'hF, "R6");
        cyc(4'b1000, 3'd2, 0, 0, 4'b0, "R5");
        peek("R5");
        cyc(4'b0111, 3'd2, 0, 0, 4'b0, "R6");
        peek("R6");
        rd_at(3'd5, "R7");
        peek("R6");
        rd_at(3'd0, "R8");
        peek("R6");
        rd_at(3'd2, "R11");
        peek("R6");
        rd_at(3'd6, "R9");
        peek("R9");

        // R11 negative then R10
        cyc(4'b0110, 3'd3, 0, 0, 4'b0, "R11");
        rd_at(3'd2, "R11");
        rd_at(3'd0, "R8");
        peek("R11");
        cyc(4'b0, 3'd0, 0, 1, 4'h0, "R10");
        peek("R10");

        // R13 set beats clear
        cyc(4'b0001, 3'd3, 0, 0, 4'b0, "R13");
        cyc(4'b0001, 3'd5, 1, 0, 4'b0, "R13");
        peek("R13");
        rd_at(3'd5, "R7");

        // R14 disabling drops the flag
        cyc(4'b0010, 3'd3, 0, 0, 4'b0, "R14");
        cyc(4'b0, 3'd1, 0, 1, 4'hE, "R14");
        cyc(4'b0, 3'd1, 0, 1, 4'hF, "R14");
        peek("R14");

        // Random mix against the model
        for (int i = 0; i < 600; i++) begin
            bit [3:0] ev;
            bit [2:0] a;
            bit rd, wr;
            int op;
            ev = 4'($urandom) & 4'($urandom);
            a  = 3'($urandom);
            op = $urandom % 4;
            rd = (op == 1) || (op == 2);
            wr = (op == 3) && (a != 3'd1 || ($urandom % 4) == 0);
            cyc(ev, a, rd, wr, 4'($urandom) | 4'($urandom), "R6");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule